// File: doc/BRIEF.md
# Neighbor Link Message Buffer

This block sits on one shared edge between two adjacent compute nodes and carries traffic in one direction only. Two copies are placed on each such edge, one for each direction. No copy is built toward a position where no node exists. The sending neighbor writes a complete 64-bit message straight into a small queue owned by the receiving node. There is no arbitration and no setup handshake. The sender sees a busy flag while it must hold off and gets a one-cycle done pulse once its message has been stored. Sends on other links of the same node are independent of this one.

The receive side serves the queue head one message at a time, in arrival order, and steers it by its 2-bit type field. A register-write message stores its 24-bit payload in one entry of a small latch file and sets that entry's valid flag. A proxy message leaves on a forwarding port. A cluster-bus message or a memory message leaves on an upward port. The owner reads a latch whenever it needs the value. It waits while the valid flag is low and clears the flag with an acknowledge.

Message layout: bits [63:62] type (00 register write, 01 proxy forward, 10 cluster-bus, 11 memory), bits [61:30] destination address, bits [29:24] latch index, bits [23:0] payload.

Top module: `nbr_link_buf`

## Requirements
- R1: After reset, snd_busy_o, snd_done_o, fwd_valid_o and up_valid_o are 0 and every latch entry reads invalid.
- R2: A message is stored on a clock edge where snd_valid_i is 1 and snd_busy_o is 0. snd_done_o is then 1 for exactly the one cycle that follows that edge.
- R3: snd_busy_o is 1 while the queue holds 4 messages. A send presented while busy is dropped: nothing is stored and no done pulse follows.
- R4: Messages leave the queue strictly in arrival order. A head that cannot be served blocks every message behind it.
- R5: A type 00 head writes its payload (bits [23:0]) to the latch entry chosen by index bits [26:24] and sets that entry's valid flag. Index bits [29:27] are ignored.
- R6: A type 00 head aimed at an entry that is still valid waits in the queue until that entry is cleared. Latched data is never overwritten.
- R7: rd_valid_o and rd_data_o show the entry selected by rd_idx_i. An edge with rd_ack_i at 1 clears that entry's valid flag.
- R8: A type 01 head is shown unchanged on fwd_msg_o with fwd_valid_o at 1. It is held stable until an edge where fwd_ready_i is 1.
- R9: A type 10 or type 11 head is shown unchanged on up_msg_o with up_valid_o at 1. It is held stable until an edge where up_ready_i is 1.
- R10: fwd_valid_o and up_valid_o are 0 while the queue is empty, and they are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snd_valid_i | input | 1 | Neighbor presents a message |
| snd_msg_i | input | 64 | Message from the neighbor |
| snd_busy_o | output | 1 | Queue full, sender must hold off |
| snd_done_o | output | 1 | One-cycle pulse after a message is stored |
| fwd_valid_o | output | 1 | Proxy message available |
| fwd_msg_o | output | 64 | Proxy message |
| fwd_ready_i | input | 1 | Forwarding path accepts |
| up_valid_o | output | 1 | Cluster-bus or memory message available |
| up_msg_o | output | 64 | Upward message |
| up_ready_i | input | 1 | Upward path accepts |
| rd_idx_i | input | 3 | Latch entry selected by the owner |
| rd_ack_i | input | 1 | Owner consumes the selected entry |
| rd_valid_o | output | 1 | Selected entry holds unread data |
| rd_data_o | output | 24 | Selected entry payload |

## Verification
The done pulse appears in the cycle right after the storing edge. A proxy or upward message becomes valid in that same cycle, because it is then the queue head. A register-write payload turns valid one cycle later, after the latch-write edge. The bench drives inputs at the falling edge and checks done and latch state at the next falling edge or the one after, matching those latencies. A monitor samples the forward and upward ports a quarter period before each rising edge and compares every accepted message against a queue of expected messages, so both content and order are checked.

// File: rtl/nlb_pkg.sv
package nlb_pkg;
  localparam int unsigned MSG_W   = 64;
  localparam int unsigned TYPE_LO = 62;
  localparam int unsigned IDX_LO  = 24;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned PAY_W   = 24;

  typedef enum logic [1:0] {
    MT_REG = 2'b00,
    MT_FWD = 2'b01,
    MT_BUS = 2'b10,
    MT_MEM = 2'b11
  } msg_type_e;

  function automatic msg_type_e msg_type(input logic [MSG_W-1:0] m);
    return msg_type_e'(m[TYPE_LO +: 2]);
  endfunction
endpackage

// File: rtl/nlb_fifo.sv
module nlb_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= inc(wptr_q);
      if (pop_i)  rptr_q <= inc(rptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH)));
  a_r10_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/nlb_latch_file.sv
module nlb_latch_file #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [$clog2(N)-1:0] wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic                 wr_occupied_o,
  input  logic [$clog2(N)-1:0] rd_idx_i,
  input  logic                 rd_ack_i,
  output logic                 rd_valid_o,
  output logic [DW-1:0]        rd_data_o
);
  logic [N-1:0]  vld_q;
  logic [DW-1:0] data_q [N];

  assign wr_occupied_o = vld_q[wr_idx_i];
  assign rd_valid_o    = vld_q[rd_idx_i];
  assign rd_data_o     = data_q[rd_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == g) begin
        vld_q[g] <= 1'b1;
      end else if (rd_ack_i && rd_idx_i == g) begin
        vld_q[g] <= 1'b0;
      end
    end
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == g) data_q[g] <= wr_data_i;
    end
  end

  a_r6_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !vld_q[wr_idx_i]);
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_i && rd_valid_o) |=> !vld_q[$past(rd_idx_i)]);
endmodule

// File: rtl/nlb_dispatch.sv
module nlb_dispatch
  import nlb_pkg::*;
(
  input  logic [MSG_W-1:0] head_i,
  input  logic             empty_i,
  input  logic             occupied_i,
  input  logic             fwd_ready_i,
  input  logic             up_ready_i,
  output logic             wr_en_o,
  output logic             fwd_valid_o,
  output logic             up_valid_o,
  output logic             pop_o
);
  msg_type_e t;
  assign t = msg_type(head_i);

  always_comb begin
    wr_en_o     = 1'b0;
    fwd_valid_o = 1'b0;
    up_valid_o  = 1'b0;
    if (!empty_i) begin
      unique case (t)
        MT_REG:         wr_en_o     = !occupied_i;
        MT_FWD:         fwd_valid_o = 1'b1;
        MT_BUS, MT_MEM: up_valid_o  = 1'b1;
        default: ;
      endcase
    end
    pop_o = wr_en_o | (fwd_valid_o & fwd_ready_i) | (up_valid_o & up_ready_i);
  end
endmodule

// File: rtl/nbr_link_buf.sv
module nbr_link_buf
  import nlb_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned NUM_LATCH = 8,
  localparam int unsigned LIW      = $clog2(NUM_LATCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snd_valid_i,
  input  logic [MSG_W-1:0] snd_msg_i,
  output logic             snd_busy_o,
  output logic             snd_done_o,
  output logic             fwd_valid_o,
  output logic [MSG_W-1:0] fwd_msg_o,
  input  logic             fwd_ready_i,
  output logic             up_valid_o,
  output logic [MSG_W-1:0] up_msg_o,
  input  logic             up_ready_i,
  input  logic [LIW-1:0]   rd_idx_i,
  input  logic             rd_ack_i,
  output logic             rd_valid_o,
  output logic [PAY_W-1:0] rd_data_o
);
  logic             push, pop, empty, full, wr_en, occupied;
  logic [MSG_W-1:0] head;
  logic             done_q;

  assign push       = snd_valid_i && !full;
  assign snd_busy_o = full;
  assign snd_done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= push;
  end

  nlb_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i(snd_msg_i), .pop_i(pop),
    .head_o(head), .empty_o(empty), .full_o(full)
  );

  nlb_dispatch u_disp (
    .head_i(head), .empty_i(empty), .occupied_i(occupied),
    .fwd_ready_i, .up_ready_i,
    .wr_en_o(wr_en), .fwd_valid_o, .up_valid_o, .pop_o(pop)
  );

  nlb_latch_file #(.N(NUM_LATCH), .DW(PAY_W)) u_latch (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(head[IDX_LO +: LIW]), .wr_data_i(head[PAY_W-1:0]),
    .wr_occupied_o(occupied),
    .rd_idx_i, .rd_ack_i, .rd_valid_o, .rd_data_o
  );

  assign fwd_msg_o = head;
  assign up_msg_o  = head;

  a_r2_done_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> snd_done_o);
  a_r2_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push |=> !snd_done_o);
  a_r8_fwd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && !fwd_ready_i) |=> (fwd_valid_o && $stable(fwd_msg_o)));
  a_r9_up_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_o && !up_ready_i) |=> (up_valid_o && $stable(up_msg_o)));
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_valid_o && up_valid_o));
endmodule

// File: tb/nbr_link_buf_tb.sv
module nbr_link_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snd_valid = 1'b0;
  logic [63:0] snd_msg = '0;
  logic        snd_busy, snd_done;
  logic        fwd_valid, up_valid;
  logic [63:0] fwd_msg, up_msg;
  logic        fwd_ready = 1'b0, up_ready = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic        rd_ack = 1'b0;
  logic        rd_valid;
  logic [23:0] rd_data;

  int checks = 0, errors = 0;
  logic [63:0] exp_fwd[$], exp_up[$];

  always #10 clk = ~clk;

  nbr_link_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .snd_valid_i(snd_valid), .snd_msg_i(snd_msg),
    .snd_busy_o(snd_busy), .snd_done_o(snd_done),
    .fwd_valid_o(fwd_valid), .fwd_msg_o(fwd_msg), .fwd_ready_i(fwd_ready),
    .up_valid_o(up_valid), .up_msg_o(up_msg), .up_ready_i(up_ready),
    .rd_idx_i(rd_idx), .rd_ack_i(rd_ack),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [1:0] t, input logic [5:0] idx,
                                     input logic [23:0] pay);
    return {t, 32'hC0DE_0000 | {26'd0, idx}, idx, pay};
  endfunction

  // drive one send; done expected at the next falling edge (R2)
  task automatic send(input logic [63:0] m);
    @(negedge clk);
    snd_valid = 1'b1;
    snd_msg   = m;
    @(negedge clk);
    snd_valid = 1'b0;
    chk("R2 done pulse", 64'(snd_done), 64'd1);
  endtask

  task automatic ack(input logic [2:0] i);
    @(negedge clk);
    rd_idx = i;
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
  endtask

  // monitor: a quarter period before each rising edge
  always @(negedge clk) begin
    #5;
    if (rst_n && fwd_valid && up_valid) chk("R10 exclusive", 64'd1, 64'd0);
    if (rst_n && fwd_valid && fwd_ready) begin
      if (exp_fwd.size() == 0) chk("R8 unexpected fwd", fwd_msg, 64'd0);
      else chk("R8/R4 fwd msg", fwd_msg, exp_fwd.pop_front());
    end
    if (rst_n && up_valid && up_ready) begin
      if (exp_up.size() == 0) chk("R9 unexpected up", up_msg, 64'd0);
      else chk("R9/R4 up msg", up_msg, exp_up.pop_front());
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] m;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(snd_busy), 64'd0);
    chk("R1 done", 64'(snd_done), 64'd0);
    chk("R1 fwd_valid", 64'(fwd_valid), 64'd0);
    chk("R1 up_valid", 64'(up_valid), 64'd0);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1 chk("R1 latch invalid", 64'(rd_valid), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R5 register write, R7 ack
    send(mk(2'b00, 6'd2, 24'hABCDEF));
    @(negedge clk);
    chk("R2 done one cycle", 64'(snd_done), 64'd0);
    rd_idx = 3'd2;
    #1;
    chk("R5 valid set", 64'(rd_valid), 64'd1);
    chk("R5 payload", 64'(rd_data), 64'hABCDEF);
    ack(3'd2);
    #1 chk("R7 ack clears", 64'(rd_valid), 64'd0);

    // R5 upper index bits ignored: 6'b101_110 -> entry 6
    send(mk(2'b00, 6'b101110, 24'h123456));
    @(negedge clk);
    rd_idx = 3'd6;
    #1;
    chk("R5 index high bits ignored", 64'(rd_valid), 64'd1);
    chk("R5 payload e6", 64'(rd_data), 64'h123456);
    ack(3'd6);

    // R6 stall on occupied entry, R4 later message blocked
    fwd_ready = 1'b1;
    send(mk(2'b00, 6'd3, 24'h111111));
    send(mk(2'b00, 6'd3, 24'h222222));
    m = mk(2'b01, 6'd9, 24'hF0F0F0);
    exp_fwd.push_back(m);
    send(m);
    repeat (3) @(negedge clk);
    rd_idx = 3'd3;
    #1;
    chk("R6 first payload kept", 64'(rd_data), 64'h111111);
    chk("R4 fwd blocked behind stall", 64'(fwd_valid), 64'd0);
    ack(3'd3);
    @(negedge clk);
    #1;
    chk("R6 second payload after ack", 64'(rd_data), 64'h222222);
    chk("R6 valid again", 64'(rd_valid), 64'd1);
    repeat (2) @(negedge clk);
    chk("R8 fwd drained", 64'(exp_fwd.size()), 64'd0);
    ack(3'd3);

    // R3 full queue, drop while busy, R8 hold, R4 order
    fwd_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      m = mk(2'b01, 6'(i), 24'(32'h500 + i));
      exp_fwd.push_back(m);
      send(m);
    end
    chk("R3 busy when full", 64'(snd_busy), 64'd1);
    chk("R8 fwd held", fwd_msg, exp_fwd[0]);
    @(negedge clk);
    snd_valid = 1'b1;
    snd_msg   = mk(2'b01, 6'd63, 24'hDEAD00);
    @(negedge clk);
    snd_valid = 1'b0;
    chk("R3 dropped send no done", 64'(snd_done), 64'd0);
    fwd_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3/R4 four drained in order", 64'(exp_fwd.size()), 64'd0);
    chk("R10 idle after drain", 64'(fwd_valid), 64'd0);
    chk("R3 busy cleared", 64'(snd_busy), 64'd0);

    // R9 upward types 10 and 11
    up_ready = 1'b0;
    m = mk(2'b10, 6'd1, 24'hB05B05);
    exp_up.push_back(m);
    send(m);
    m = mk(2'b11, 6'd2, 24'h3E3E3E);
    exp_up.push_back(m);
    send(m);
    chk("R9 up valid", 64'(up_valid), 64'd1);
    chk("R9 up held", up_msg, exp_up[0]);
    chk("R10 fwd idle on up head", 64'(fwd_valid), 64'd0);
    up_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 up drained", 64'(exp_up.size()), 64'd0);
    chk("R10 up idle when empty", 64'(up_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule